// File: doc/BRIEF.md
# Sectored Data Cache Fill Controller

This block handles misses and allocation for a small two-way set-associative data cache. Each way of a set is one sector: a single address tag covers two 32-byte lines, and each line keeps its own MESI state. The CPU side presents reads and byte-enabled writes. A request that hits a valid line finishes at once. A miss holds the CPU stalled while the controller fetches the line from memory as a four-beat burst of 64-bit words. It then installs the line in the tag, state and data arrays and returns the requested word.

A miss is one of two kinds. In a tag miss, no way of the set holds the sector, so the victim way is re-tagged and its other line is dropped. In a tag hit, the sector is present but the requested line is Invalid, so only that line is refilled. Victims are picked by least-recently-allocated order. When write allocation is on, a write miss fetches the line and merges the write bytes into it. Two memory-side attributes, a write-back flag and a cacheable flag, are sampled on the first beat. Together with the request's page write-through bit, they set the state the line is installed in.

Address layout: bits 2:0 are the byte, bits 4:3 the 64-bit word within a line, bit 5 the line within the sector, the next log2(SETS) bits the set index, and the rest the tag.

Top module: `scache_fill_ctrl`

## Requirements
- R1: A read or write that hits a non-Invalid line raises `cpu_ready` in the same cycle it is presented, issues no burst, and a read returns the current word of that line.
- R2: A miss issues exactly one burst: `mem_rd_req` stays high, with a stable address whose bits 4:0 are zero, until four `mem_rvalid` beats (word 0 first) have been taken. `cpu_ready` stays low throughout and rises in the cycle after the fourth beat, six cycles after the request when beats come back to back.
- R3: On a tag miss the victim way is re-tagged, and the other line of that sector becomes Invalid, so a later access to it misses.
- R4: On a tag-hit fill, the way holding the sector is reused and only the requested line is fetched. The other line keeps its state and data and still hits.
- R5: The victim on a tag miss is the way allocated least recently in that set. Only installing fills update this order; hits never do.
- R6: With write allocation on (`wa_en`=1), a cacheable write miss fetches the line and then merges the write into it, where byte enable bit i selects data bits 8i+7:8i. Later reads return the merged word, and the other words come from memory.
- R7: A line filled with `mem_wb`=1 and `cpu_pwt`=0 is installed privately: Exclusive after a read, Modified after a merged write, and no memory write follows. Any other fill installs the line Shared, and the merged write of a write allocation is also sent to memory.
- R8: A write hit on an Exclusive or Modified line leaves the line Modified and produces no memory write. A write hit on a Shared line keeps it Shared and drives one `mem_wr` cycle with the request's address, data and byte enables in the completing cycle.
- R9: If `mem_cacheable` is low on the first beat, a read gets the fetched word and a write is sent to memory with `mem_wr`. Nothing is installed, and tags, states and allocation order are unchanged.
- R10: With `wa_en`=0, a write miss completes in one cycle as a single `mem_wr` cycle, with no burst and no change to any cache state.
- R11: After reset every line is Invalid, and `cpu_ready`, `mem_rd_req` and `mem_wr` are low while no request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request valid, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 64 | Write data |
| cpu_be | input | 8 | Write byte enables |
| cpu_pwt | input | 1 | Page write-through attribute of the request |
| wa_en | input | 1 | Write allocation enable |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 64 | Read data, valid with `cpu_ready` |
| mem_rd_req | output | 1 | Burst read in progress |
| mem_rd_addr | output | ADDR_W | Line-aligned burst address |
| mem_rvalid | input | 1 | Burst beat valid |
| mem_rdata | input | 64 | Burst beat data |
| mem_cacheable | input | 1 | Line may be cached, sampled on the first beat |
| mem_wb | input | 1 | Write-back attribute, sampled on the first beat |
| mem_wr | output | 1 | Single memory write this cycle |
| mem_wr_addr | output | ADDR_W | Memory write address |
| mem_wr_data | output | 64 | Memory write data |
| mem_wr_be | output | 8 | Memory write byte enables |

## Verification
On every cycle the assertions check the burst handshake: the stall during a fill, the line-aligned and steady burst address, the count of four beats per burst, the same-cycle completion of hits, and that memory writes appear only in a completing cycle and never during a burst. Sibling-line invalidation and preservation, the least-recently-allocated victim choice, merged write data, Shared-versus-private installation, and the non-installing outcomes of uncacheable fills and non-allocating writes depend on earlier transactions. Only the directed scenarios, each followed by probing accesses, can show these.

// File: rtl/scache_pkg.sv
`timescale 1ns/1ps
package scache_pkg;
    localparam int DATA_W     = 64;
    localparam int BE_W       = DATA_W / 8;
    localparam int BEATS      = 4;
    localparam int WORD_W     = $clog2(BEATS);
    localparam int LINE_BIT   = 5;
    localparam int SECTOR_OFS = 6;

    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_E = 2'd2,
        LS_M = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_FILL = 2'd1,
        FS_DONE = 2'd2
    } fill_st_e;

    typedef logic [BEATS-1:0][DATA_W-1:0] line_t;

    typedef struct packed {
        logic              we;
        logic              pwt;
        logic [DATA_W-1:0] wdata;
        logic [BE_W-1:0]   be;
    } wreq_t;

    function automatic logic [DATA_W-1:0] byte_merge(
        input logic [DATA_W-1:0] old_w,
        input logic [DATA_W-1:0] new_w,
        input logic [BE_W-1:0]   be
    );
        logic [DATA_W-1:0] r;
        r = old_w;
        for (int b = 0; b < BE_W; b++) begin
            if (be[b]) r[8*b +: 8] = new_w[8*b +: 8];
        end
        return r;
    endfunction

    function automatic line_st_e install_state(
        input logic wb,
        input logic pwt,
        input logic we
    );
        if (wb && !pwt) return we ? LS_M : LS_E;
        return LS_S;
    endfunction
endpackage

// File: rtl/scache_tag_store.sv
`timescale 1ns/1ps
module scache_tag_store
    import scache_pkg::*;
#(
    parameter int SETS  = 4,
    parameter int TAG_W = 8,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_set,
    output logic [TAG_W-1:0] rd_tag [2],
    output line_st_e         rd_st [2][2],
    output logic             rd_victim,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_set,
    input  logic             upd_way,
    input  logic             upd_line,
    input  line_st_e         upd_state,
    input  logic             upd_new_tag,
    input  logic [TAG_W-1:0] upd_tag,
    input  logic             upd_alloc
);
    logic [TAG_W-1:0] tag_q [SETS][2];
    line_st_e         st_q  [SETS][2][2];
    logic [SETS-1:0]  lra_q;

    always_comb begin
        for (int w = 0; w < 2; w++) begin
            rd_tag[w] = tag_q[rd_set][w];
            for (int l = 0; l < 2; l++) rd_st[w][l] = st_q[rd_set][w][l];
        end
        rd_victim = lra_q[rd_set];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lra_q <= '0;
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < 2; w++) begin
                    tag_q[s][w] <= '0;
                    for (int l = 0; l < 2; l++) st_q[s][w][l] <= LS_I;
                end
            end
        end else if (upd_en) begin
            st_q[upd_set][upd_way][upd_line] <= upd_state;
            if (upd_new_tag) begin
                tag_q[upd_set][upd_way]            <= upd_tag;
                st_q[upd_set][upd_way][!upd_line]  <= LS_I;
            end
            if (upd_alloc) lra_q[upd_set] <= !upd_way;
        end
    end
endmodule

// File: rtl/scache_data_store.sv
`timescale 1ns/1ps
module scache_data_store
    import scache_pkg::*;
#(
    parameter int SETS = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int ENT_W = IDX_W + 2,
    localparam int ENTRIES = 2 ** ENT_W
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_set,
    input  logic              rd_way,
    input  logic              rd_line,
    input  logic [WORD_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data,
    input  logic [IDX_W-1:0]  wr_set,
    input  logic              wr_way,
    input  logic              wr_line,
    input  logic              line_we,
    input  line_t             line_data,
    input  logic              word_we,
    input  logic [WORD_W-1:0] word_idx,
    input  logic [DATA_W-1:0] word_data,
    input  logic [BE_W-1:0]   word_be
);
    logic [DATA_W-1:0] mem_q [ENTRIES][BEATS];
    logic [ENT_W-1:0]  rd_ent, wr_ent;

    assign rd_ent  = {rd_set, rd_way, rd_line};
    assign wr_ent  = {wr_set, wr_way, wr_line};
    assign rd_data = mem_q[rd_ent][rd_word];

    always_ff @(posedge clk) begin
        if (line_we) begin
            for (int b = 0; b < BEATS; b++) mem_q[wr_ent][b] <= line_data[b];
        end else if (word_we) begin
            mem_q[wr_ent][word_idx] <= byte_merge(mem_q[wr_ent][word_idx], word_data, word_be);
        end
    end
endmodule

// File: rtl/scache_fill_ctrl.sv
`timescale 1ns/1ps
module scache_fill_ctrl
    import scache_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SETS   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [63:0]       cpu_wdata,
    input  logic [7:0]        cpu_be,
    input  logic              cpu_pwt,
    input  logic              wa_en,
    output logic              cpu_ready,
    output logic [63:0]       cpu_rdata,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rvalid,
    input  logic [63:0]       mem_rdata,
    input  logic              mem_cacheable,
    input  logic              mem_wb,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [63:0]       mem_wr_data,
    output logic [7:0]        mem_wr_be
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - SECTOR_OFS - IDX_W;

    // request field decode
    logic [IDX_W-1:0]  a_idx, rq_idx;
    logic [TAG_W-1:0]  a_tag, rq_tag;
    logic              a_line, rq_line;
    logic [WORD_W-1:0] a_word, rq_word;

    fill_st_e          fsm_q;
    logic [ADDR_W-1:0] rq_addr;
    wreq_t             rq_w;
    logic              rq_way, rq_taghit;
    logic [WORD_W-1:0] beat_q;
    line_t             buf_q, merged_buf;
    logic              attr_c_q, attr_wb_q;

    assign a_idx   = cpu_addr[SECTOR_OFS +: IDX_W];
    assign a_tag   = cpu_addr[ADDR_W-1 -: TAG_W];
    assign a_line  = cpu_addr[LINE_BIT];
    assign a_word  = cpu_addr[3 +: WORD_W];
    assign rq_idx  = rq_addr[SECTOR_OFS +: IDX_W];
    assign rq_tag  = rq_addr[ADDR_W-1 -: TAG_W];
    assign rq_line = rq_addr[LINE_BIT];
    assign rq_word = rq_addr[3 +: WORD_W];

    // tag store
    logic [TAG_W-1:0]  rd_tag [2];
    line_st_e          rd_st  [2][2];
    logic              rd_victim;
    logic              upd_en, upd_way, upd_line, upd_new_tag, upd_alloc;
    logic [IDX_W-1:0]  upd_set;
    line_st_e          upd_state;

    scache_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) i_tags (
        .clk(clk), .rst(rst), .rd_set(a_idx), .rd_tag(rd_tag), .rd_st(rd_st),
        .rd_victim(rd_victim), .upd_en(upd_en), .upd_set(upd_set), .upd_way(upd_way),
        .upd_line(upd_line), .upd_state(upd_state), .upd_new_tag(upd_new_tag),
        .upd_tag(rq_tag), .upd_alloc(upd_alloc)
    );

    // hit detection per way
    logic [1:0] way_tag_hit, line_hit;
    for (genvar w = 0; w < 2; w++) begin : g_way
        assign way_tag_hit[w] = (rd_tag[w] == a_tag) &&
                                ((rd_st[w][0] != LS_I) || (rd_st[w][1] != LS_I));
        assign line_hit[w]    = way_tag_hit[w] && (rd_st[w][a_line] != LS_I);
    end

    logic     any_hit, hit_way, tag_hit_any, victim_way;
    line_st_e hit_st;
    assign any_hit     = |line_hit;
    assign hit_way     = line_hit[1];
    assign tag_hit_any = |way_tag_hit;
    assign victim_way  = tag_hit_any ? way_tag_hit[1] : rd_victim;
    assign hit_st      = rd_st[hit_way][a_line];

    // data store
    logic [63:0]       rd_data;
    logic [IDX_W-1:0]  wr_set;
    logic              wr_way, wr_line, line_we, word_we;

    scache_data_store #(.SETS(SETS)) i_data (
        .clk(clk), .rd_set(a_idx), .rd_way(hit_way), .rd_line(a_line), .rd_word(a_word),
        .rd_data(rd_data), .wr_set(wr_set), .wr_way(wr_way), .wr_line(wr_line),
        .line_we(line_we), .line_data(merged_buf), .word_we(word_we), .word_idx(a_word),
        .word_data(cpu_wdata), .word_be(cpu_be)
    );

    always_comb begin
        merged_buf = buf_q;
        if (rq_w.we) merged_buf[rq_word] = byte_merge(buf_q[rq_word], rq_w.wdata, rq_w.be);
    end

    logic wb_fill;
    assign wb_fill     = attr_c_q && attr_wb_q && !rq_w.pwt;
    assign mem_rd_req  = (fsm_q == FS_FILL);
    assign mem_rd_addr = {rq_addr[ADDR_W-1:LINE_BIT], {LINE_BIT{1'b0}}};

    always_comb begin
        cpu_ready   = 1'b0;
        cpu_rdata   = rd_data;
        mem_wr      = 1'b0;
        mem_wr_addr = cpu_addr;
        mem_wr_data = cpu_wdata;
        mem_wr_be   = cpu_be;
        upd_en      = 1'b0;
        upd_set     = a_idx;
        upd_way     = hit_way;
        upd_line    = a_line;
        upd_state   = LS_M;
        upd_new_tag = 1'b0;
        upd_alloc   = 1'b0;
        wr_set      = a_idx;
        wr_way      = hit_way;
        wr_line     = a_line;
        line_we     = 1'b0;
        word_we     = 1'b0;
        case (fsm_q)
            FS_IDLE: begin
                if (cpu_req && any_hit) begin
                    cpu_ready = 1'b1;
                    if (cpu_we) begin
                        word_we = 1'b1;
                        if (hit_st == LS_S) mem_wr = 1'b1;
                        else                upd_en = 1'b1;
                    end
                end else if (cpu_req && cpu_we && !wa_en) begin
                    cpu_ready = 1'b1;
                    mem_wr    = 1'b1;
                end
            end
            FS_DONE: begin
                cpu_ready   = 1'b1;
                cpu_rdata   = buf_q[rq_word];
                mem_wr_addr = rq_addr;
                mem_wr_data = rq_w.wdata;
                mem_wr_be   = rq_w.be;
                mem_wr      = rq_w.we && !wb_fill;
                upd_set     = rq_idx;
                upd_way     = rq_way;
                upd_line    = rq_line;
                wr_set      = rq_idx;
                wr_way      = rq_way;
                wr_line     = rq_line;
                if (attr_c_q) begin
                    upd_en      = 1'b1;
                    upd_state   = install_state(attr_wb_q, rq_w.pwt, rq_w.we);
                    upd_new_tag = !rq_taghit;
                    upd_alloc   = 1'b1;
                    line_we     = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q     <= FS_IDLE;
            beat_q    <= '0;
            rq_addr   <= '0;
            rq_w      <= '0;
            rq_way    <= 1'b0;
            rq_taghit <= 1'b0;
            attr_c_q  <= 1'b0;
            attr_wb_q <= 1'b0;
        end else begin
            case (fsm_q)
                FS_IDLE: begin
                    if (cpu_req && !any_hit && !(cpu_we && !wa_en)) begin
                        fsm_q     <= FS_FILL;
                        beat_q    <= '0;
                        rq_addr   <= cpu_addr;
                        rq_w      <= '{we: cpu_we, pwt: cpu_pwt, wdata: cpu_wdata, be: cpu_be};
                        rq_way    <= victim_way;
                        rq_taghit <= tag_hit_any;
                    end
                end
                FS_FILL: begin
                    if (mem_rvalid) begin
                        buf_q[beat_q] <= mem_rdata;
                        if (beat_q == '0) begin
                            attr_c_q  <= mem_cacheable;
                            attr_wb_q <= mem_wb;
                        end
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == WORD_W'(BEATS - 1)) fsm_q <= FS_DONE;
                    end
                end
                default: fsm_q <= FS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/scache_fill_chk.sv
`timescale 1ns/1ps
module scache_fill_chk
    import scache_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req,
    input logic              cpu_ready,
    input logic              mem_rd_req,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rvalid,
    input logic              mem_wr,
    input fill_st_e          fsm_q,
    input logic              any_hit
);
    logic [2:0] beat_cnt;

    always_ff @(posedge clk) begin
        if (rst)                          beat_cnt <= '0;
        else if (mem_rd_req && mem_rvalid) beat_cnt <= beat_cnt + 1'b1;
        else if (!mem_rd_req)             beat_cnt <= '0;
    end

    AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> cpu_req); // R1
    AST_HIT_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (fsm_q == FS_IDLE && cpu_req && any_hit) |-> cpu_ready); // R1
    AST_FILL_STALLS: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |-> !cpu_ready); // R2
    AST_FILL_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |-> (mem_rd_addr[4:0] == 5'd0)); // R2
    AST_FILL_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |=> (!mem_rd_req || $stable(mem_rd_addr))); // R2
    AST_FOUR_BEATS: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_rd_req) |-> (beat_cnt == 3'(BEATS))); // R2
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_req && mem_wr)); // R10
    AST_WR_ON_COMPLETE: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> cpu_ready); // R8
endmodule

bind scache_fill_ctrl scache_fill_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rvalid(mem_rvalid),
    .mem_wr(mem_wr), .fsm_q(fsm_q), .any_hit(any_hit)
);

// File: tb/test_scache_fill_ctrl.sv
`timescale 1ns/1ps
module test_scache_fill_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_pwt = 1'b0, wa_en = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [63:0] cpu_wdata = '0;
    logic [7:0]  cpu_be = '0;
    logic        cpu_ready;
    logic [63:0] cpu_rdata;
    logic        mem_rd_req;
    logic [15:0] mem_rd_addr;
    logic        mem_rvalid = 1'b0, mem_cacheable = 1'b1, mem_wb = 1'b1;
    logic [63:0] mem_rdata = '0;
    logic        mem_wr;
    logic [15:0] mem_wr_addr;
    logic [63:0] mem_wr_data;
    logic [7:0]  mem_wr_be;

    always #4 clk = ~clk;

    scache_fill_ctrl i_scache_fill_ctrl (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_pwt(cpu_pwt), .wa_en(wa_en),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .mem_rd_req(mem_rd_req),
        .mem_rd_addr(mem_rd_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .mem_cacheable(mem_cacheable), .mem_wb(mem_wb), .mem_wr(mem_wr),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be)
    );

    int n_checks = 0, n_fail = 0;
    logic cache_attr = 1'b1, wb_attr = 1'b1;
    logic [63:0] mem_m  [int];
    logic [63:0] view_m [int];

    logic [63:0] res_rd, res_wdata;
    logic [15:0] res_rdaddr, res_waddr;
    logic [7:0]  res_wbe;
    int          res_cyc, res_nwr;
    bit          res_burst;

    function automatic logic [63:0] pat(int w);
        return {16'hC0DE ^ w[15:0], w[15:0], ~w[15:0], 16'h3A5F + w[15:0]};
    endfunction
    function automatic logic [63:0] merge64(logic [63:0] o, logic [63:0] n, logic [7:0] be);
        logic [63:0] r = o;
        for (int b = 0; b < 8; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction
    function automatic logic [63:0] mem_rd(int w);
        return mem_m.exists(w) ? mem_m[w] : pat(w);
    endfunction
    function automatic logic [63:0] view_rd(int w);
        return view_m.exists(w) ? view_m[w] : pat(w);
    endfunction
    function automatic logic [15:0] mk(int tag, int set, int line, int word);
        return {tag[7:0], set[1:0], line[0], word[1:0], 3'b000};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [15:0] a, input logic [63:0] wd,
                          input logic [7:0] be, input logic pwt);
        int beat = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be; cpu_pwt = pwt;
        res_cyc = 0; res_nwr = 0; res_burst = 0;
        forever begin
            #1;
            res_cyc++;
            if (mem_rd_req && beat < 4) begin
                res_burst = 1; res_rdaddr = mem_rd_addr;
                mem_rvalid = 1'b1;
                mem_rdata = mem_rd(int'(mem_rd_addr >> 3) + beat);
                mem_cacheable = cache_attr; mem_wb = wb_attr;
                beat++;
            end else mem_rvalid = 1'b0;
            if (mem_wr) begin
                res_nwr++;
                res_waddr = mem_wr_addr; res_wdata = mem_wr_data; res_wbe = mem_wr_be;
                mem_m[int'(mem_wr_addr >> 3)] = merge64(mem_rd(int'(mem_wr_addr >> 3)),
                                                         mem_wr_data, mem_wr_be);
            end
            if (cpu_ready) begin
                res_rd = cpu_rdata;
                break;
            end
            if (res_cyc > 50) begin
                chk(0, "R2", "request never completed", 64'(res_cyc), 64'd6);
                break;
            end
            @(negedge clk);
        end
        @(posedge clk);
        #1;
        cpu_req = 1'b0; mem_rvalid = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a, input bit exp_fill, input string req);
        access(1'b0, a, 64'h0, 8'h00, 1'b0);
        chk(res_burst == exp_fill, req, "burst issued", 64'(res_burst), 64'(exp_fill));
        chk(res_rd == view_rd(int'(a >> 3)), req, "read data", res_rd, view_rd(int'(a >> 3)));
        chk(res_cyc == (exp_fill ? 6 : 1), req, "cycles to ready", 64'(res_cyc),
            64'(exp_fill ? 6 : 1));
        if (exp_fill)
            chk(res_rdaddr == (a & 16'hFFE0), "R2", "burst address", 64'(res_rdaddr),
                64'(a & 16'hFFE0));
    endtask

    task automatic do_write(input logic [15:0] a, input logic [63:0] wd, input logic [7:0] be,
                            input logic pwt, input bit exp_fill, input int exp_nwr,
                            input string req);
        access(1'b1, a, wd, be, pwt);
        chk(res_burst == exp_fill, req, "burst issued", 64'(res_burst), 64'(exp_fill));
        chk(res_nwr == exp_nwr, req, "memory writes", 64'(res_nwr), 64'(exp_nwr));
        chk(res_cyc == (exp_fill ? 6 : 1), req, "cycles to ready", 64'(res_cyc),
            64'(exp_fill ? 6 : 1));
        if (exp_nwr > 0 && res_nwr > 0) begin
            chk(res_waddr == a, req, "write address", 64'(res_waddr), 64'(a));
            chk(res_wdata == wd, req, "write data", res_wdata, wd);
            chk(res_wbe == be, req, "write enables", 64'(res_wbe), 64'(be));
        end
        view_m[int'(a >> 3)] = merge64(view_rd(int'(a >> 3)), wd, be);
    endtask

    task automatic t_reset();
        #1;
        chk(cpu_ready == 1'b0, "R11", "ready after reset", 64'(cpu_ready), 64'd0);
        chk(mem_rd_req == 1'b0, "R11", "burst after reset", 64'(mem_rd_req), 64'd0);
        chk(mem_wr == 1'b0, "R11", "write after reset", 64'(mem_wr), 64'd0);
    endtask

    task automatic t_read_fill();
        do_read(mk(1, 0, 0, 2), 1, "R11");   // cold cache misses
        do_read(mk(1, 0, 0, 2), 0, "R1");
        do_read(mk(1, 0, 0, 3), 0, "R1");
        do_read(mk(1, 0, 1, 1), 1, "R4");    // tag-hit fill of sibling
        do_read(mk(1, 0, 0, 0), 0, "R4");    // first line kept
    endtask

    task automatic t_sibling_invalidate();
        do_read(mk(2, 1, 0, 0), 1, "R3");
        do_read(mk(2, 1, 1, 0), 1, "R4");
        do_read(mk(3, 1, 0, 0), 1, "R3");
        do_read(mk(4, 1, 1, 0), 1, "R3");    // evicts way holding tag 2
        do_read(mk(4, 1, 0, 0), 1, "R3");    // sibling dropped by re-tag
        do_read(mk(3, 1, 0, 0), 0, "R3");
        do_read(mk(2, 1, 0, 0), 1, "R3");
    endtask

    task automatic t_lra_order();
        do_read(mk(5, 2, 0, 0), 1, "R5");
        do_read(mk(6, 2, 0, 0), 1, "R5");
        for (int i = 0; i < 3; i++) do_read(mk(5, 2, 0, i), 0, "R5");
        do_read(mk(7, 2, 0, 0), 1, "R5");    // oldest allocation is tag 5
        do_read(mk(6, 2, 0, 0), 0, "R5");
        do_read(mk(5, 2, 0, 0), 1, "R5");
    endtask

    task automatic t_uncacheable();
        cache_attr = 1'b0;
        do_read(mk(8, 2, 0, 1), 1, "R9");
        do_read(mk(8, 2, 0, 1), 1, "R9");    // not installed
        do_write(mk(8, 2, 0, 2), 64'h1122334455667788, 8'hFF, 1'b0, 1, 1, "R9");
        cache_attr = 1'b1;
        do_read(mk(9, 2, 0, 0), 1, "R9");    // evicts tag 7, order unchanged
        do_read(mk(5, 2, 0, 0), 0, "R9");
    endtask

    task automatic t_write_through();
        wb_attr = 1'b0;
        do_read(mk(10, 3, 0, 0), 1, "R7");
        wb_attr = 1'b1;
        do_write(mk(10, 3, 0, 1), 64'hDEADBEEFCAFEF00D, 8'h0F, 1'b0, 0, 1, "R8");
        do_read(mk(10, 3, 0, 1), 0, "R8");
    endtask

    task automatic t_write_private();
        do_read(mk(11, 3, 0, 0), 1, "R7");
        do_write(mk(11, 3, 0, 2), 64'h0123456789ABCDEF, 8'hF0, 1'b0, 0, 0, "R8");
        do_write(mk(11, 3, 0, 2), 64'hFFEEDDCCBBAA9988, 8'h01, 1'b0, 0, 0, "R8");
        do_read(mk(11, 3, 0, 2), 0, "R8");
    endtask

    task automatic t_write_alloc_wb();
        do_write(mk(12, 0, 1, 3), 64'hA1B2C3D4E5F60718, 8'h3C, 1'b0, 1, 0, "R6");
        do_read(mk(12, 0, 1, 3), 0, "R6");
        do_read(mk(12, 0, 1, 0), 0, "R6");
        do_write(mk(12, 0, 1, 3), 64'h5555AAAA5555AAAA, 8'h80, 1'b0, 0, 0, "R7");
        do_read(mk(12, 0, 0, 0), 1, "R3");
    endtask

    task automatic t_write_alloc_wt();
        do_write(mk(13, 1, 0, 1), 64'h0F1E2D3C4B5A6978, 8'hFF, 1'b1, 1, 1, "R7");
        do_write(mk(13, 1, 0, 1), 64'h00000000000000AB, 8'h01, 1'b0, 0, 1, "R7");
        do_read(mk(13, 1, 0, 1), 0, "R7");
    endtask

    task automatic t_no_allocate();
        wa_en = 1'b0;
        do_write(mk(14, 3, 1, 2), 64'h13579BDF2468ACE0, 8'hFF, 1'b0, 0, 1, "R10");
        wa_en = 1'b1;
        do_read(mk(11, 3, 0, 2), 0, "R10");
        do_read(mk(10, 3, 0, 1), 0, "R10");
        do_read(mk(14, 3, 1, 2), 1, "R10");
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_fill();
        t_sibling_invalidate();
        t_lra_order();
        t_uncacheable();
        t_write_through();
        t_write_private();
        t_write_alloc_wb();
        t_write_alloc_wt();
        t_no_allocate();
        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule